// File: doc/BRIEF.md
# Mode-Dependent Sync Generator

This block derives horizontal and vertical sync for a CCD timing chain from the master clock. Each line is made up of a fixed number of clocks. Each field is a whole number of such lines followed by one shorter closing line. The number of lines and the length of that closing line are chosen by a three-bit drive mode and a pattern select, which picks a 60 Hz-like or a 50 Hz-like field. In the 50 Hz-like frame mode there is no partial line. Instead, the final two lines of the field are both cut short.

The block exposes active-low horizontal and vertical sync, a line counter that starts at 1, and a clock-in-line counter that starts at 0. Downstream pulse logic decodes these two counters. The mode inputs may change at any time. They are captured only on the clock edge that opens a new field, which is the edge where vertical sync goes low. As a result, a field is never stretched or cut part way through.

All lengths are parameters. The defaults are 2288 clocks per line, a 115-clock horizontal sync, and the field lengths listed below.

Top module: `sync_gen`

## Requirements
- R1: With pattern select low, the field lengths are as follows. Frame: 918 full lines, then line 919 of 1716 clocks. Draft: 262 full lines, then a 1144-clock line. AF1: 131 full lines, then a 572-clock line. AF2: 65 full lines, then a 1430-clock line.
- R2: With pattern select high, the field lengths are as follows. Draft: 314 full lines, then a 1568-clock line. AF1: 157 full lines, then a 784-clock line. AF2: 78 full lines, then a 1536-clock line. Frame: exactly 945 lines.
- R3: In frame mode with pattern select high, the last two lines of the field (944 and 945 by default) each last 1208 clocks. Every earlier line in that field is full length.
- R4: `mode_sel` and `pal_sel` are sampled only on the edge that starts a new field. A change made during a field does not alter that field's length.
- R5: `hd_n` is low for exactly the first HD_LOW clocks of every line (clock counts 0 to HD_LOW-1). The default is 115.
- R6: `vd_n` is low for the whole of the first line of each field and high for the rest of the field.
- R7: Within a line, `pix_cnt` counts up by one per clock from 0. At the end of a line it returns to 0 and `line_cnt` steps by one. After the last line of a field, `line_cnt` returns to 1.
- R8: The `mode_sel` encoding is: 000 draft; 001, 010 and 011 frame (frame A field, frame B field and frame all give the same field length); 100 and 101 AF1; 110 and 111 AF2.
- R9: A synchronous active-high `rst` forces line 1, clock 0, draft mode and the 60 Hz-like pattern, whatever the mode inputs are. The field that follows reset has the draft 60 Hz-like length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 3 | Drive mode request (encoding in R8) |
| pal_sel | input | 1 | Pattern select: 0 = 60 Hz-like, 1 = 50 Hz-like |
| hd_n | output | 1 | Horizontal sync, active low |
| vd_n | output | 1 | Vertical sync, active low |
| line_cnt | output | LINE_W | Line number in field, from 1 |
| pix_cnt | output | CLK_W | Clock number in line, from 0 |

## Verification
The state of this block is entirely its two counters and the captured mode. Any fault shows at the ports no later than the end of the field it corrupts.

A wrong captured mode, or a wrong length lookup, moves the next vertical sync fall. It also changes the highest line number reached and the clock count of the last line or two. A slip in the line or clock counter breaks the one-step progression within a cycle or two, and it shifts where the horizontal sync edge lands. The bench therefore measures each whole field at the ports, for every mode code, for both patterns, and across reset.

// File: rtl/sync_gen.sv
module sync_gen #(
  parameter int LINE_CLKS = 2288,
  parameter int HD_LOW    = 115,
  parameter int N_FRM_H   = 918,
  parameter int N_FRM_C   = 1716,
  parameter int N_DRF_H   = 262,
  parameter int N_DRF_C   = 1144,
  parameter int N_AF1_H   = 131,
  parameter int N_AF1_C   = 572,
  parameter int N_AF2_H   = 65,
  parameter int N_AF2_C   = 1430,
  parameter int P_FRM_H   = 945,
  parameter int P_SHORT   = 1208,
  parameter int P_DRF_H   = 314,
  parameter int P_DRF_C   = 1568,
  parameter int P_AF1_H   = 157,
  parameter int P_AF1_C   = 784,
  parameter int P_AF2_H   = 78,
  parameter int P_AF2_C   = 1536,
  parameter int LINE_W    = 10,
  parameter int CLK_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              pal_sel,
  output logic              hd_n,
  output logic              vd_n,
  output logic [LINE_W-1:0] line_cnt,
  output logic [CLK_W-1:0]  pix_cnt
);

  localparam logic [1:0] C_DRF = 2'd0;
  localparam logic [1:0] C_FRM = 2'd1;
  localparam logic [1:0] C_AF1 = 2'd2;
  localparam logic [1:0] C_AF2 = 2'd3;

  function automatic logic [1:0] mode_class(input logic [2:0] m);
    if (m[2]) return m[1] ? C_AF2 : C_AF1;
    return (m[1:0] == 2'b00) ? C_DRF : C_FRM;
  endfunction

  logic [1:0] cls_q;
  logic       pal_q;
  int         full_h, tail_c, last_line, cur_len;
  logic       pal_frame, end_line, end_field;

  always_comb begin
    case (cls_q)
      C_DRF:   begin full_h = pal_q ? P_DRF_H : N_DRF_H; tail_c = pal_q ? P_DRF_C : N_DRF_C; end
      C_FRM:   begin full_h = pal_q ? P_FRM_H : N_FRM_H; tail_c = pal_q ? P_SHORT : N_FRM_C; end
      C_AF1:   begin full_h = pal_q ? P_AF1_H : N_AF1_H; tail_c = pal_q ? P_AF1_C : N_AF1_C; end
      default: begin full_h = pal_q ? P_AF2_H : N_AF2_H; tail_c = pal_q ? P_AF2_C : N_AF2_C; end
    endcase
  end

  assign pal_frame = pal_q && (cls_q == C_FRM);
  assign last_line = pal_frame ? full_h : full_h + 1;

  always_comb begin
    if (pal_frame)
      cur_len = (int'(line_cnt) >= full_h - 1) ? tail_c : LINE_CLKS;
    else
      cur_len = (int'(line_cnt) == last_line) ? tail_c : LINE_CLKS;
  end

  assign end_line  = int'(pix_cnt) == cur_len - 1;
  assign end_field = end_line && (int'(line_cnt) == last_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt  <= '0;
      line_cnt <= LINE_W'(1);
      cls_q    <= C_DRF;
      pal_q    <= 1'b0;
    end else if (end_line) begin
      pix_cnt <= '0;
      if (end_field) begin
        line_cnt <= LINE_W'(1);
        cls_q    <= mode_class(mode_sel);
        pal_q    <= pal_sel;
      end else begin
        line_cnt <= line_cnt + LINE_W'(1);
      end
    end else begin
      pix_cnt <= pix_cnt + CLK_W'(1);
    end
  end

  assign hd_n = !(int'(pix_cnt) < HD_LOW);
  assign vd_n = !(line_cnt == LINE_W'(1));

endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
  parameter int HD_LOW = 115,
  parameter int LINE_W = 10,
  parameter int CLK_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              hd_n,
  input logic              vd_n,
  input logic [LINE_W-1:0] line_cnt,
  input logic [CLK_W-1:0]  pix_cnt
);

  p_pix_step_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != '0) |-> (pix_cnt == CLK_W'($past(pix_cnt) + CLK_W'(1))));

  p_line_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != '0) |-> (line_cnt == $past(line_cnt)));

  p_line_step_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt == '0 && line_cnt != LINE_W'(1)) |-> (line_cnt == LINE_W'($past(line_cnt) + LINE_W'(1))));

  p_line_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    line_cnt != '0);

  p_vd_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(vd_n) |-> (pix_cnt == '0));

  p_hd_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hd_n) |-> (int'(pix_cnt) == HD_LOW));

endmodule

bind sync_gen sync_gen_chk #(.HD_LOW(HD_LOW), .LINE_W(LINE_W), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .hd_n(hd_n), .vd_n(vd_n), .line_cnt(line_cnt), .pix_cnt(pix_cnt)
);

// File: tb/sync_gen_tb.sv
module sync_gen_tb;
  localparam int LINE = 40;
  localparam int HDL  = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'b110;
  logic       pal_sel = 1'b1;
  logic       hd_n, vd_n;
  logic [9:0] line_cnt;
  logic [11:0] pix_cnt;

  sync_gen #(
    .LINE_CLKS(LINE), .HD_LOW(HDL),
    .N_FRM_H(9), .N_FRM_C(30), .N_DRF_H(5), .N_DRF_C(20),
    .N_AF1_H(4), .N_AF1_C(10), .N_AF2_H(3), .N_AF2_C(25),
    .P_FRM_H(10), .P_SHORT(22), .P_DRF_H(6), .P_DRF_C(28),
    .P_AF1_H(5), .P_AF1_C(12), .P_AF2_H(2), .P_AF2_C(35)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pal_sel(pal_sel),
    .hd_n(hd_n), .vd_n(vd_n), .line_cnt(line_cnt), .pix_cnt(pix_cnt)
  );

  // mode, pal, field length, last line, last line length, second-last line length
  localparam int NV = 10;
  localparam int VEC [NV][6] = '{
    '{1, 0, 390, 10, 30, 40},
    '{0, 1, 268,  7, 28, 40},
    '{4, 0, 170,  5, 10, 40},
    '{7, 1, 115,  3, 35, 40},
    '{3, 1, 364, 10, 22, 22},
    '{5, 1, 212,  6, 12, 40},
    '{6, 0, 145,  4, 25, 40},
    '{2, 0, 390, 10, 30, 40},
    '{2, 1, 364, 10, 22, 22},
    '{0, 0, 220,  6, 20, 40}
  };

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure(output int len, output int lastl, output int lastlen,
                         output int prevlen, output int hdl, output int vdl);
    len = 0; lastl = 0; lastlen = 0; prevlen = 0; hdl = 0; vdl = 0;
    do begin
      len++;
      if (!hd_n) hdl++;
      if (!vd_n) vdl++;
      if (int'(line_cnt) > lastl) begin
        prevlen = lastlen;
        lastl = int'(line_cnt);
        lastlen = 0;
      end
      lastlen++;
      @(negedge clk);
    end while (!(line_cnt == 10'd1 && pix_cnt == 12'd0));
  endtask

  task automatic check_field(input string req, input int e_len, input int e_last,
                             input int e_ll, input int e_pl);
    int len, lastl, lastlen, prevlen, hdl, vdl;
    measure(len, lastl, lastlen, prevlen, hdl, vdl);
    chk(req, "field length", len, e_len);
    chk("R7", "last line number", lastl, e_last);
    chk(req, "last line clocks", lastlen, e_ll);
    chk("R3", "second-last line clocks", prevlen, e_pl);
    chk("R5", "hd low clocks per field", hdl, e_last * HDL);
    chk("R6", "vd low clocks per field", vdl, LINE);
  endtask

  initial begin
    int p_len, p_last, p_ll, p_pl;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "line in reset", int'(line_cnt), 1);
    chk("R9", "pix in reset", int'(pix_cnt), 0);
    chk("R9", "vd_n in reset", int'(vd_n), 0);
    chk("R9", "hd_n in reset", int'(hd_n), 0);
    rst = 1'b0;
    // R9: first field is draft 60 Hz-like although inputs request AF2 50 Hz-like
    check_field("R9", 220, 6, 20, 40);
    p_len = 115; p_last = 3; p_ll = 35; p_pl = 40;
    for (int i = 0; i < NV; i++) begin
      mode_sel = 3'(VEC[i][0]);
      pal_sel  = VEC[i][1] != 0;
      // R4: change made inside a field leaves that field unchanged
      check_field("R4", p_len, p_last, p_ll, p_pl);
      // R1/R2/R8: requested mode takes effect in the following field
      check_field(VEC[i][1] != 0 ? "R2" : "R1", VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
      p_len = VEC[i][2]; p_last = VEC[i][3]; p_ll = VEC[i][4]; p_pl = VEC[i][5];
    end
    // R8: alias codes measured above (001/010/011 frame, 100/101 AF1, 110/111 AF2)
    // R9: mid-field reset
    mode_sel = 3'b011; pal_sel = 1'b1;
    repeat (57) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "line after mid-field reset", int'(line_cnt), 1);
    chk("R9", "pix after mid-field reset", int'(pix_cnt), 0);
    rst = 1'b0;
    check_field("R9", 220, 6, 20, 40);
    check_field("R3", 364, 10, 22, 22);
    // R7: counters at a known point in line 2
    repeat (LINE + 7) @(negedge clk);
    chk("R7", "line in second line", int'(line_cnt), 2);
    chk("R7", "pix in second line", int'(pix_cnt), 7);
    chk("R5", "hd_n past sync width", int'(hd_n), 1);
    chk("R6", "vd_n on second line", int'(vd_n), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule